// File: doc/BRIEF.md
# Peripheral Bus Protocol Compliance Monitor

This block sits passively on a simple two-phase peripheral bus segment that fans out to several targets, each with its own select line. It never drives the bus. Every clock it looks at the selects, the enable, the direction, the address, the write data, the byte strobes, the protection attribute, the ready and the error response. It raises a sticky flag for each protocol rule that is broken and records the code of the first rule that failed. It also keeps saturating statistics on completed writes, completed reads, wait cycles and transfers that completed with an error.

A transfer on this bus starts with a setup cycle, in which a select is high and enable is low. It then moves to an access phase, in which enable is high. The access phase may be stretched by the target holding ready low. The transfer completes on the first cycle in which select, enable and ready are all high. The monitor does not judge whether data is correct. It only checks the handshake, exclusivity, stability and strobe rules. A pulse on the clear input re-arms the flags.

Top module: `pbus_monitor`

## Requirements
- R1: After a synchronous active-low reset, all violation flags are 0, the violation code is 0 and all four counters are 0.
- R2: A cycle with a select high and enable high, when the previous cycle was neither a setup cycle nor an access wait cycle, sets flag bit 0 (code 1).
- R3: A setup cycle that is not followed by a cycle with select and enable both high (setup lasting two cycles or being abandoned) sets flag bit 1 (code 2).
- R4: When the previous cycle was a setup or access wait cycle, any change in selects, direction, address, write data, strobes or protection sets flag bit 2 (code 3).
- R5: When the previous cycle was an access wait cycle (select and enable high, ready low), a cycle in which select or enable is low sets flag bit 3 (code 4).
- R6: A cycle with more than one select line high sets flag bit 4 (code 5).
- R7: A selected cycle with the direction input low (read) and any strobe bit high sets flag bit 5 (code 6).
- R8: Enable high in the cycle right after a completion sets flag bit 6 (code 7). A new setup cycle (enable low) right after a completion raises nothing.
- R9: The error response input is only sampled at completion. When it is high in setup or wait cycles, it sets no flag and leaves the error counter unchanged.
- R10: A flag set by a violation in cycle t is visible after the clock edge that ends cycle t. It stays set until a clear. The code holds the first violation. When several rules fail in the same cycle, the lowest code is recorded.
- R11: A clear pulse zeroes all flags and the code at the next edge. A violation in the clear cycle itself is discarded. The counters are not touched by clear.
- R12: At each completion the write or read counter increments according to direction. The error counter increments when the error response is high at completion. The wait counter increments on every select-and-enable cycle with ready low. All counters saturate at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Pulse to clear the sticky flags and the code |
| bus_sel | input | NSEL | Per-target select lines |
| bus_en | input | 1 | Access-phase enable |
| bus_write | input | 1 | Direction, 1 = write, 0 = read |
| bus_addr | input | AW | Address |
| bus_wdata | input | DW | Write data |
| bus_strb | input | DW/8 | Byte-lane write strobes |
| bus_prot | input | 3 | Protection attribute |
| bus_ready | input | 1 | Target ready, low stretches the access phase |
| bus_err | input | 1 | Target error response |
| viol_flags | output | 7 | Sticky per-rule flags, bit k is code k+1 |
| viol_code | output | 3 | Code of the first violation, 0 = none |
| cnt_wr | output | CNTW | Completed writes |
| cnt_rd | output | CNTW | Completed reads |
| cnt_wait | output | CNTW | Access wait cycles |
| cnt_err | output | CNTW | Transfers completed with an error |

## Verification
The bench builds the monitor with three select lines, an 8-bit address, a 16-bit data bus (two strobe lanes) and 4-bit counters. The narrow counters let a few dozen transfers drive every statistic into saturation. Three selects are enough to make a two-hot select pattern. Each rule is provoked by a hand-built bus sequence shaped so that no other rule fires by accident. Other sequences make two rules fire in one cycle to check the lowest-code capture, and put a clear and a violation in the same cycle.

// File: rtl/pbm_pkg.sv
// Package: shared constants for the bus compliance monitor.
// Assumes rule bit k of the flag vector carries violation code k+1.
package pbm_pkg;
    localparam int NRULE = 7;
    localparam int CODEW = 3;

    // flag bit positions (code = bit + 1, lower code wins on ties)
    localparam int B_ORDER    = 0;
    localparam int B_SETUPLEN = 1;
    localparam int B_HOLD     = 2;
    localparam int B_WAITDROP = 3;
    localparam int B_MULTISEL = 4;
    localparam int B_RDSTRB   = 5;
    localparam int B_ENAFTER  = 6;

    // counter slots
    localparam int NCNT   = 4;
    localparam int C_WR   = 0;
    localparam int C_RD   = 1;
    localparam int C_WAIT = 2;
    localparam int C_ERR  = 3;
endpackage

// File: rtl/pbm_rules.sv
// Module: rule evaluation for the bus compliance monitor.
// Keeps one cycle of bus history (phase class and a snapshot of the held
// signals) and produces a per-rule hit vector for the current cycle, plus
// completion and wait-cycle strobes. Assumes all inputs are synchronous to clk.
module pbm_rules
    import pbm_pkg::*;
#(
    parameter int NSEL = 4,
    parameter int AW   = 12,
    parameter int DW   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSEL-1:0]  bus_sel,
    input  logic             bus_en,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [DW/8-1:0]  bus_strb,
    input  logic [2:0]       bus_prot,
    input  logic             bus_ready,
    output logic [NRULE-1:0] hit,
    output logic             done,
    output logic             wait_cyc
);
    localparam int SW    = DW / 8;
    localparam int SNAPW = NSEL + 1 + AW + DW + SW + 3;

    logic             sel_any;
    logic             setup_now;
    logic             multi_sel;
    logic [SNAPW-1:0] snap_now;
    logic [SNAPW-1:0] snap_q;
    logic             prev_setup;
    logic             prev_wait;
    logic             prev_done;

    // classify the current cycle
    always_comb begin
        sel_any   = |bus_sel;
        setup_now = sel_any && !bus_en;
        wait_cyc  = sel_any && bus_en && !bus_ready;
        done      = sel_any && bus_en && bus_ready;
        multi_sel = (bus_sel & (bus_sel - NSEL'(1))) != '0;
        snap_now  = {bus_sel, bus_write, bus_addr, bus_wdata, bus_strb, bus_prot};
    end

    // one cycle of history: phase class and held-signal snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_setup <= 1'b0;
            prev_wait  <= 1'b0;
            prev_done  <= 1'b0;
            snap_q     <= '0;
        end else begin
            prev_setup <= setup_now;
            prev_wait  <= wait_cyc;
            prev_done  <= done;
            snap_q     <= snap_now;
        end
    end

    // per-rule violation detection for this cycle
    always_comb begin
        hit             = '0;
        hit[B_ORDER]    = sel_any && bus_en && !(prev_setup || prev_wait);
        hit[B_SETUPLEN] = prev_setup && !(sel_any && bus_en);
        hit[B_HOLD]     = (prev_setup || prev_wait) && (snap_now != snap_q);
        hit[B_WAITDROP] = prev_wait && !(sel_any && bus_en);
        hit[B_MULTISEL] = multi_sel;
        hit[B_RDSTRB]   = sel_any && !bus_write && (bus_strb != '0);
        hit[B_ENAFTER]  = prev_done && bus_en;
    end

    // R5: a stretched access that keeps select and enable raises no drop hit
    a_r5_wait_hold_clean: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cyc ##1 (sel_any && bus_en) |-> !hit[B_WAITDROP]);
endmodule

// File: rtl/pbm_flags.sv
// Module: sticky violation flags and first-failure code.
// Flags OR in the rule hits every cycle; the code latches the lowest-numbered
// hit while empty. Clear has priority over hits in the same cycle.
module pbm_flags
    import pbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [NRULE-1:0] hit,
    output logic [NRULE-1:0] flags,
    output logic [CODEW-1:0] code
);
    logic [CODEW-1:0] first;

    // pick the lowest-numbered rule hit this cycle
    always_comb begin
        first = '0;
        for (int i = NRULE - 1; i >= 0; i--) begin
            if (hit[i]) first = CODEW'(i + 1);
        end
    end

    // accumulate flags and capture the first code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            code  <= '0;
        end else if (clr) begin
            flags <= '0;
            code  <= '0;
        end else begin
            flags <= flags | hit;
            if (code == '0) code <= first;
        end
    end

    // R10: set flags never drop without clear
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));
    // R10: a recorded code is held until clear
    a_r10_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (code != '0 && !clr) |=> $stable(code));
    // R10: a code is present exactly when some flag is set
    a_r10_code_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) == (flags == '0));
    // R11: clear empties flags and code
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags == '0 && code == '0));
endmodule

// File: rtl/pbm_satcnt.sv
// Module: saturating event counter.
// Increments on inc until all ones, then holds. Only reset zeroes it.
module pbm_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = '1;

    // count events, stop at the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (inc && cnt != MAXV) cnt <= cnt + 1'b1;
    end

    // R12: no wrap past the ceiling
    a_r12_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV) |=> (cnt == MAXV));
    // R12: without an event the count holds
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt));
endmodule

// File: rtl/pbus_monitor.sv
// Module: passive compliance monitor for a two-phase peripheral bus.
// Watches all bus signals, flags handshake, stability, exclusivity and
// strobe-rule violations, and counts transfer statistics. Drives nothing on
// the bus. Assumes a single clock and a synchronous active-low reset.
module pbus_monitor
    import pbm_pkg::*;
#(
    parameter int NSEL = 4,
    parameter int AW   = 12,
    parameter int DW   = 32,
    parameter int CNTW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [NSEL-1:0]  bus_sel,
    input  logic             bus_en,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [DW/8-1:0]  bus_strb,
    input  logic [2:0]       bus_prot,
    input  logic             bus_ready,
    input  logic             bus_err,
    output logic [NRULE-1:0] viol_flags,
    output logic [CODEW-1:0] viol_code,
    output logic [CNTW-1:0]  cnt_wr,
    output logic [CNTW-1:0]  cnt_rd,
    output logic [CNTW-1:0]  cnt_wait,
    output logic [CNTW-1:0]  cnt_err
);
    logic [NRULE-1:0] hit;
    logic             done;
    logic             wait_cyc;
    logic [NCNT-1:0]  inc;
    logic [CNTW-1:0]  cnt_all [NCNT];

    pbm_rules #(.NSEL(NSEL), .AW(AW), .DW(DW)) u_rules (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_en(bus_en), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
        .bus_prot(bus_prot), .bus_ready(bus_ready),
        .hit(hit), .done(done), .wait_cyc(wait_cyc)
    );

    pbm_flags u_flags (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hit(hit),
        .flags(viol_flags), .code(viol_code)
    );

    // statistic events; the error response matters only at completion
    always_comb begin
        inc         = '0;
        inc[C_WR]   = done && bus_write;
        inc[C_RD]   = done && !bus_write;
        inc[C_WAIT] = wait_cyc;
        inc[C_ERR]  = done && bus_err;
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        pbm_satcnt #(.W(CNTW)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(inc[g]), .cnt(cnt_all[g])
        );
    end

    assign cnt_wr   = cnt_all[C_WR];
    assign cnt_rd   = cnt_all[C_RD];
    assign cnt_wait = cnt_all[C_WAIT];
    assign cnt_err  = cnt_all[C_ERR];

    // R6: two-hot select is flagged at the next edge
    a_r6_multi_sel: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(bus_sel) > 1 && !clr) |=> viol_flags[B_MULTISEL]);
    // R7: read with strobes is flagged
    a_r7_read_strb: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_sel && !bus_write && |bus_strb && !clr) |=> viol_flags[B_RDSTRB]);
    // R2: access straight from idle is flagged
    a_r2_no_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|bus_sel) && !clr) ##1 (|bus_sel && bus_en && !clr) |=> viol_flags[B_ORDER]);
    // R3: a second setup cycle is flagged
    a_r3_long_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_sel && !bus_en && !clr) ##1 (|bus_sel && !bus_en && !clr) |=> viol_flags[B_SETUPLEN]);
    // R8: enable kept high after a completion is flagged
    a_r8_en_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_sel && bus_en && bus_ready && !clr) ##1 (bus_en && !clr) |=> viol_flags[B_ENAFTER]);
endmodule

// File: tb/pbus_monitor_tb.sv
// Bench: scoreboard for the bus compliance monitor. Driver tasks build bus
// sequences and push expected flag/code/counter states into a queue; a
// monitor process pops and compares them at the falling edge.
module pbus_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS    = 3;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int SW    = DW / 8;
    localparam int CW    = 4;
    localparam int NR    = 7;
    localparam int CODEW = 3;
    localparam int PW    = NR + CODEW + 4 * CW;
    localparam int MAXC  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic [NS-1:0] sel = '0;
    logic en = 1'b0;
    logic wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wd = '0;
    logic [SW-1:0] strb = '0;
    logic [2:0] prot = '0;
    logic rdy = 1'b0;
    logic err = 1'b0;

    logic [NR-1:0]    viol_flags;
    logic [CODEW-1:0] viol_code;
    logic [CW-1:0]    cnt_wr, cnt_rd, cnt_wait, cnt_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pbus_monitor #(.NSEL(NS), .AW(AW), .DW(DW), .CNTW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .bus_sel(sel), .bus_en(en), .bus_write(wr), .bus_addr(addr),
        .bus_wdata(wd), .bus_strb(strb), .bus_prot(prot),
        .bus_ready(rdy), .bus_err(err),
        .viol_flags(viol_flags), .viol_code(viol_code),
        .cnt_wr(cnt_wr), .cnt_rd(cnt_rd), .cnt_wait(cnt_wait), .cnt_err(cnt_err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [PW-1:0] expq[$];
    string tagq[$];

    logic [NR-1:0]    ef = '0;
    logic [CODEW-1:0] ec = '0;
    logic [CW-1:0]    ewr = '0, erd = '0, ewt = '0, eer = '0;

    function automatic logic [CW-1:0] sat(input logic [CW-1:0] x);
        return (x == CW'(MAXC)) ? x : x + 1'b1;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input string t);
        expq.push_back({ef, ec, ewr, erd, ewt, eer});
        tagq.push_back(t);
    endtask

    // mark an expected violation by code; call lower codes first
    task automatic expect_code(input int c);
        ef[c-1] = 1'b1;
        if (ec == '0) ec = CODEW'(c);
    endtask

    task automatic idle();
        clr = 1'b0; sel = '0; en = 1'b0; rdy = 1'b0; err = 1'b0; strb = '0;
        step();
    endtask

    task automatic do_clear(input string t);
        clr = 1'b1; sel = '0; en = 1'b0; rdy = 1'b0; err = 1'b0;
        step();
        clr = 1'b0;
        ef = '0; ec = '0;
        push(t);
    endtask

    // well-formed transfer: setup, nwait waits, completion
    task automatic xfer(input logic [NS-1:0] s, input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [SW-1:0] st,
                        input int nwait, input logic e, input string t);
        clr = 1'b0; sel = s; en = 1'b0; wr = w; addr = a; wd = d; strb = st;
        prot = 3'b010; rdy = 1'b0; err = 1'b0;
        step();
        for (int i = 0; i < nwait; i++) begin
            en = 1'b1; rdy = 1'b0;
            step();
            ewt = sat(ewt);
        end
        en = 1'b1; rdy = 1'b1; err = e;
        step();
        if (w) ewr = sat(ewr); else erd = sat(erd);
        if (e) eer = sat(eer);
        err = 1'b0; rdy = 1'b0;
        push(t);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            logic [PW-1:0] e;
            logic [PW-1:0] g;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            g = {viol_flags, viol_code, cnt_wr, cnt_rd, cnt_wait, cnt_err};
            checks++;
            if (g !== e) begin
                errors++;
                $display("FAIL %s: got flags=%b code=%0d wr=%0d rd=%0d wait=%0d err=%0d, expected flags=%b code=%0d wr=%0d rd=%0d wait=%0d err=%0d",
                    t, viol_flags, viol_code, cnt_wr, cnt_rd, cnt_wait, cnt_err,
                    e[PW-1 -: NR], e[4*CW +: CODEW], e[3*CW +: CW], e[2*CW +: CW],
                    e[CW +: CW], e[0 +: CW]);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run still busy, expected it to finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        idle();
        push("R1 reset state");

        // R12 well-formed traffic, R8 back-to-back without idle
        xfer(3'b001, 1'b1, 8'h10, 16'hA5A5, 2'b11, 0, 1'b0, "R12 write no wait");
        idle();
        xfer(3'b010, 1'b0, 8'h20, 16'h0000, 2'b00, 2, 1'b0, "R12 read two waits");
        idle();
        xfer(3'b100, 1'b1, 8'h30, 16'h1234, 2'b01, 1, 1'b1, "R12 write with error");
        xfer(3'b001, 1'b0, 8'h31, 16'h0000, 2'b00, 0, 1'b0, "R8 new setup after completion is clean");
        idle();

        // R9: error response outside completion
        sel = 3'b010; en = 1'b0; wr = 1'b1; addr = 8'h44; wd = 16'h0F0F; strb = 2'b10;
        rdy = 1'b0; err = 1'b1;
        step();
        en = 1'b1; step(); ewt = sat(ewt);
        rdy = 1'b1; err = 1'b0; step(); ewr = sat(ewr);
        push("R9 error response outside completion ignored");
        idle();

        // R6: two selects through a whole transfer
        expect_code(5);
        xfer(3'b011, 1'b1, 8'h50, 16'h5555, 2'b11, 0, 1'b0, "R6 two selects high");
        idle();
        push("R10 flag stays set");
        do_clear("R11 clear empties flags");

        // R2: access without setup
        sel = 3'b001; en = 1'b1; rdy = 1'b1; wr = 1'b1; strb = 2'b11;
        step(); ewr = sat(ewr); expect_code(1);
        push("R2 access without setup");
        idle();
        do_clear("R11 clear after R2");

        // R3: setup held two cycles
        sel = 3'b100; en = 1'b0; wr = 1'b1; addr = 8'h60; rdy = 1'b0; strb = 2'b11;
        step(); step();
        en = 1'b1; rdy = 1'b1; step(); ewr = sat(ewr); expect_code(2);
        push("R3 setup lasting two cycles");
        idle();
        do_clear("R11 clear after R3");

        // R4: address change into access
        sel = 3'b001; en = 1'b0; wr = 1'b1; addr = 8'h70; wd = 16'h0001; strb = 2'b11;
        step();
        addr = 8'h71; en = 1'b1; rdy = 1'b1; step(); ewr = sat(ewr); expect_code(3);
        push("R4 address changed after setup");
        idle();
        do_clear("R11 clear after R4 address");

        // R4: write data change during wait
        sel = 3'b010; en = 1'b0; wr = 1'b1; addr = 8'h72; wd = 16'h1111; strb = 2'b01;
        step();
        en = 1'b1; rdy = 1'b0; step(); ewt = sat(ewt);
        wd = 16'h2222; step(); ewt = sat(ewt); expect_code(3);
        rdy = 1'b1; step(); ewr = sat(ewr);
        push("R4 write data changed during wait");
        idle();
        do_clear("R11 clear after R4 data");

        // R5: enable dropped during wait
        sel = 3'b100; en = 1'b0; wr = 1'b0; addr = 8'h80; strb = 2'b00;
        step();
        en = 1'b1; rdy = 1'b0; step(); ewt = sat(ewt);
        en = 1'b0; step(); expect_code(4);
        en = 1'b1; rdy = 1'b1; step(); erd = sat(erd);
        push("R5 enable dropped in wait");
        idle();
        do_clear("R11 clear after R5");

        // R7: read with a strobe bit
        expect_code(6);
        xfer(3'b001, 1'b0, 8'h90, 16'h0000, 2'b01, 0, 1'b0, "R7 read with strobe");
        idle();
        do_clear("R11 clear after R7");

        // R8: enable held after completion with select low
        xfer(3'b010, 1'b1, 8'hA0, 16'hBEEF, 2'b11, 0, 1'b0, "R12 write before R8");
        sel = '0; en = 1'b1; rdy = 1'b0; step(); expect_code(7);
        push("R8 enable high after completion");
        idle();
        do_clear("R11 clear after R8");

        // R10: two rules in one cycle, lowest code recorded
        xfer(3'b100, 1'b1, 8'hB0, 16'hCAFE, 2'b11, 0, 1'b0, "R12 write before R10 priority");
        en = 1'b1; rdy = 1'b1; step(); ewr = sat(ewr);
        expect_code(1); expect_code(7);
        push("R10 lowest code among simultaneous");
        idle();
        do_clear("R11 clear after R10");

        // R11: clear wins over a same-cycle violation
        clr = 1'b1; sel = 3'b011; en = 1'b1; rdy = 1'b1; wr = 1'b0; strb = 2'b00;
        step(); clr = 1'b0; erd = sat(erd);
        push("R11 clear discards same-cycle violation");
        idle();
        push("R11 nothing raised after clear cycle");

        // R12: saturation of every counter
        for (int k = 0; k < 17; k++) begin
            xfer(3'b001, 1'b1, 8'hC0, 16'h0A0A, 2'b11, 1, 1'b1, "R12 saturating write/wait/error");
            xfer(3'b010, 1'b0, 8'hC1, 16'h0000, 2'b00, 0, 1'b0, "R12 saturating read");
        end
        idle();
        push("R12 counters held at ceiling");

        wait (expq.size() == 0);
        @(negedge clk);
        #1;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule